// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block divides an input clock by an integer ratio whose high phase and low phase are programmed separately. A high-phase field N and a low-phase field M give a divided output that is high for N + 1 input cycles and low for M + 1 input cycles, so the total ratio is N + M + 2. A bypass flag passes the input clock straight through for divide-by-one.

A synchronous sync input resets the block. While sync is high, the output sits at a programmed start level, the counters are held, and the configuration inputs are captured. When sync is released, the block waits a programmed number of whole input cycles. It then runs, and its first phase is the phase that matches the start level. The configuration is frozen from that release until the next sync, so writing new settings mid-run never disturbs the output.

For odd ratios set up with M = N + 1, an optional correction adds half an input cycle to every high phase. This is done with a register clocked on the falling edge, and it gives a 50% duty cycle.

Top module: `clk_ratio_div`

## Requirements
- R1: With bypass off and correction off, the output is high for N + 1 input cycles and low for M + 1 input cycles, repeating with period N + M + 2.
- R2: The two phases are independent, so asymmetric duty works: for example, N=0/M=3 and N=2/M=1 both divide by 5, with high times of 1 and 3 cycles.
- R3: Every ratio from 2 (N=M=0) to 64 (N=M=31) is produced, including the divide-by-32 setting N=M=15.
- R4: When the bypass flag is captured as 1, the output equals the input clock whenever sync is low.
- R5: After sync is released, the output stays at the start level for the programmed delay of 0 to 31 cycles before the first phase begins to count.
- R6: With start level 1 the first phase after the delay is the high phase (N + 1 cycles); with start level 0 it is the low phase (M + 1 cycles).
- R7: While sync is high, the output is held at the start-level input and the phase counter and delay counter are held at their initial values.
- R8: With correction enabled and M = N + 1, each high phase lasts N + 1.5 input cycles and each low phase N + 1.5 cycles; the extra half cycle follows the falling edge of the divided output.
- R9: With correction enabled but M not equal to N + 1, the correction has no effect and the output is the same as with correction off.
- R10: Changes to any configuration input while sync is low have no effect; the values captured during the last sync cycle stay in force until sync is asserted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| sync_i | input | 1 | Synchronous hold/restart, active high |
| high_len_i | input | 5 | N: high phase lasts N + 1 cycles |
| low_len_i | input | 5 | M: low phase lasts M + 1 cycles |
| delay_i | input | 5 | Start delay in input cycles |
| bypass_i | input | 1 | Divide-by-one pass-through |
| start_high_i | input | 1 | Output level held during sync and delay |
| even_duty_i | input | 1 | Enables half-cycle duty correction |
| clk_o | output | 1 | Divided clock |

## Verification
The embedded properties check the following on every cycle:
- a sync cycle leaves the output at the requested start level;
- the level never moves while the start delay is counting;
- the phase counter stays within the current phase length;
- the level toggles exactly when a phase completes and at no other time.

Some behaviour shows only over whole periods and half cycles, so the bench's directed scenarios cover it. This includes the exact high and low lengths for each ratio and the half-cycle stretch from correction. It also includes the pass-through in bypass, and the output being unaffected when the configuration is changed during a run.

// File: rtl/clk_ratio_div.sv
module clk_ratio_div #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          sync_i,
  input  logic [CW-1:0] high_len_i,
  input  logic [CW-1:0] low_len_i,
  input  logic [CW-1:0] delay_i,
  input  logic          bypass_i,
  input  logic          start_high_i,
  input  logic          even_duty_i,
  output logic          clk_o
);

  logic [CW-1:0] high_q, low_q, dly_q, cnt_q;
  logic          byp_q, fix_en_q, lvl_q, neg_q;
  logic [CW-1:0] last;
  logic          fix_ok;

  assign last   = lvl_q ? high_q : low_q;
  assign fix_ok = fix_en_q && ({1'b0, low_q} == {1'b0, high_q} + 1'b1);

  always_ff @(posedge clk_i) begin
    if (sync_i) begin
      high_q   <= high_len_i;
      low_q    <= low_len_i;
      byp_q    <= bypass_i;
      fix_en_q <= even_duty_i;
      dly_q    <= delay_i;
      cnt_q    <= '0;
      lvl_q    <= start_high_i;
    end else if (dly_q != '0) begin
      dly_q <= dly_q - 1'b1;
    end else if (cnt_q == last) begin
      cnt_q <= '0;
      lvl_q <= ~lvl_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(negedge clk_i) neg_q <= lvl_q;

  assign clk_o = (byp_q && !sync_i) ? clk_i : (lvl_q | (fix_ok & neg_q));

  AST_SYNC_START: assert property (@(posedge clk_i)
    sync_i |=> lvl_q == $past(start_high_i)); // R7

  AST_DELAY_STILL: assert property (@(posedge clk_i) disable iff (sync_i)
    (dly_q != '0) |=> $stable(lvl_q)); // R5

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (sync_i)
    (dly_q == '0) |-> cnt_q <= (lvl_q ? high_q : low_q)); // R1

  AST_TOGGLE_AT_END: assert property (@(posedge clk_i) disable iff (sync_i)
    (dly_q == '0 && cnt_q == last) |=> lvl_q != $past(lvl_q)); // R1

  AST_HOLD_MID_PHASE: assert property (@(posedge clk_i) disable iff (sync_i)
    (dly_q == '0 && cnt_q != last) |=> $stable(lvl_q)); // R2

endmodule

// File: tb/clk_ratio_div_test.sv
module clk_ratio_div_test;
  logic clk = 1'b0;
  logic sync = 1'b1;
  logic [4:0] hi = '0, lo = '0, dly = '0;
  logic byp = 1'b0, st = 1'b1, fix = 1'b0;
  logic out;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  clk_ratio_div uut (
    .clk_i(clk), .sync_i(sync), .high_len_i(hi), .low_len_i(lo),
    .delay_i(dly), .bypass_i(byp), .start_high_i(st), .even_duty_i(fix),
    .clk_o(out)
  );

  function automatic logic exp_lvl(int k, int n, int m, int p, logic s);
    int j, d, l0, mm;
    if (k <= p) return s;
    j  = k - p - 1;
    d  = n + m + 2;
    l0 = s ? n + 1 : m + 1;
    mm = (j + 1) % d;
    return (mm < l0) ? s : ~s;
  endfunction

  task automatic check(string tag, logic act, logic expv, int k);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: step %0d actual %b expected %b", tag, k, act, expv);
    end
  endtask

  task automatic run_case(string tag, int n, int m, int p, logic s,
                          logic f, logic b, logic scramble);
    logic corr, prev, cur;
    int cycles;
    corr = f && (m == n + 1) && !b;
    cycles = p + 3 * (n + m + 2) + 4;
    @(negedge clk);
    hi = n[4:0]; lo = m[4:0]; dly = p[4:0]; st = s; fix = f; byp = b;
    sync = 1'b1;
    repeat (2) @(negedge clk);
    #2 check({tag, " R7 hold"}, out, s, 0);
    sync = 1'b0;
    if (scramble) begin
      hi = ~hi; lo = lo + 5'd3; dly = ~dly; st = ~st; fix = ~fix; byp = ~byp;
    end
    prev = s;
    for (int k = 1; k <= cycles; k++) begin
      cur = exp_lvl(k, n, m, p, s);
      @(posedge clk); #2;
      check(tag, out, b ? 1'b1 : (corr ? (cur | prev) : cur), k);
      @(negedge clk); #2;
      check(tag, out, b ? 1'b0 : cur, k);
      prev = cur;
    end
  endtask

  task automatic t_basic;      run_case("R1 div8", 3, 3, 0, 1'b1, 1'b0, 1'b0, 1'b0); endtask
  task automatic t_asym;
    run_case("R2 5=1+4", 0, 3, 0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_case("R2 5=3+2", 2, 1, 0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic t_range;
    run_case("R3 div2",  0, 0, 0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_case("R3 div32", 15, 15, 0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_case("R3 div64", 31, 31, 0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic t_bypass;     run_case("R4 bypass", 3, 5, 4, 1'b0, 1'b0, 1'b1, 1'b0); endtask
  task automatic t_delay;
    run_case("R5 delay7",  2, 4, 7, 1'b1, 1'b0, 1'b0, 1'b0);
    run_case("R5 delay31", 1, 1, 31, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic t_start_low;  run_case("R6 startlow", 4, 1, 3, 1'b0, 1'b0, 1'b0, 1'b0); endtask
  task automatic t_correct;
    run_case("R8 fix5", 1, 2, 0, 1'b1, 1'b1, 1'b0, 1'b0);
    run_case("R8 fix7lo", 2, 3, 2, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask
  task automatic t_fix_ignored; run_case("R9 nofix", 2, 2, 0, 1'b1, 1'b1, 1'b0, 1'b0); endtask
  task automatic t_frozen;     run_case("R10 frozen", 2, 4, 3, 1'b1, 1'b0, 1'b0, 1'b1); endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_basic;
    t_asym;
    t_range;
    t_bypass;
    t_delay;
    t_start_low;
    t_correct;
    t_fix_ignored;
    t_frozen;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule